// File: doc/BRIEF.md
# Iterative Unsigned Multiplier

This block multiplies two unsigned operands by repeated conditional addition and right shifting, one step per clock. On a start pulse it captures the multiplicand into its own register and places the multiplier in the lower half of a double-width accumulator whose upper half is cleared. Each step looks at the accumulator's lowest bit. When that bit is set, the multiplicand is added into the upper half. The whole accumulator then moves right by one position, and the adder's carry enters at the top. As the partial product grows, the multiplier bits are used up from the bottom, so no separate multiplier register is needed and the adder spans only one operand width.

After WIDTH steps the accumulator holds the full double-width product. A one-cycle completion pulse is raised, and the result stays unchanged until the next start. A start request that arrives while a multiplication is running has no effect.

Top module: `seq_mul`

## Requirements
- R1: A synchronous active-high reset returns the block to idle with busy low, done low and product zero.
- R2: When start is high while the block is idle, busy goes high on the next clock edge and the operands are captured on that edge.
- R3: Once the operands are captured, the product equals the unsigned product of multiplicand and multiplier exactly WIDTH clock cycles later (WIDTH = 32 by default).
- R4: The done output is high for exactly one cycle. It is high in the same cycle that busy falls.
- R5: A start pulse while busy is high is ignored. The running operation finishes with its original operands at its original time.
- R6: The carry out of each step's addition is kept, so operands at their maximum value produce the correct full-width product with no lost bits.
- R7: After done, the product output keeps its value until the next accepted start.
- R8: The busy output stays high for exactly WIDTH consecutive cycles per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only when idle |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Double-width product |

## Verification
The bench drives all-ones operands into both inputs, because a design that drops the step carry returns a truncated upper half there. Zero operands, a multiplier of one and a single high bit in the multiplier each check the step count and the shift direction; an off-by-one loop gives a product doubled or halved. A start pulse in the middle of a run, carrying different operands, shows whether a design wrongly restarts or mixes the new operands into the result. The bench also counts the busy cycles and watches the result after done, to catch a late or stretched done pulse and a result that drifts while idle.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0]   mcand_q;
  logic [2*WIDTH-1:0] acc_q;
  logic [CW-1:0]      steps_q;
  logic               busy_q, done_q;
  logic [WIDTH:0]     upper_sum;
  logic               last_step;

  assign upper_sum = acc_q[0] ? ({1'b0, acc_q[2*WIDTH-1:WIDTH]} + {1'b0, mcand_q})
                              : {1'b0, acc_q[2*WIDTH-1:WIDTH]};
  assign last_step = (steps_q == CW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      steps_q <= '0;
      mcand_q <= '0;
      acc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          steps_q <= '0;
          mcand_q <= mcand;
          acc_q   <= {{WIDTH{1'b0}}, mplier};
        end
      end else begin
        acc_q   <= {upper_sum, acc_q[WIDTH-1:1]};
        steps_q <= steps_q + 1'b1;
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;

  assert_done_on_busy_fall_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($fell(busy) && !busy));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(product));
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> (busy && $stable(mcand_q)));
  assert_step_count_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> (steps_q == '0));
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && product == '0));
endmodule

// File: tb/seq_mul_tb.sv
module seq_mul_tb;
  localparam int W = 32;
  logic clk = 0, rst = 1, start = 0;
  logic [W-1:0] mcand = 0, mplier = 0;
  logic busy, done;
  logic [2*W-1:0] product;
  int checks = 0, fails = 0;
  bit finished = 0;

  seq_mul #(.WIDTH(W)) u_dut (.clk, .rst, .start, .mcand, .mplier, .busy, .done, .product);

  always #4 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic chk(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] a, logic [W-1:0] b, bit poke, string req);
    int bc = 0;
    bit seen_done = 0;
    @(negedge clk); mcand = a; mplier = b; start = 1;
    @(negedge clk); start = 0;
    chk("R2 busy", busy, 1);
    for (int i = 0; i < W; i++) begin
      if (busy) bc++;
      if (done) seen_done = 1;
      if (poke && i == 5) begin start = 1; mcand = ~a; mplier = ~b; end
      @(negedge clk); start = 0;
    end
    chk("R8 busy cycles", bc, W);
    chk("R4 done", done, 1);
    chk("R4 busy low", busy, 0);
    chk("R4 no early done", seen_done, 0);
    chk(req, product, ref_mul(a, b));
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R7 hold", product, ref_mul(a, b));
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
    rst = 0;
    run('1, '1, 0, "R6 max operands");
    run(0, 32'h1234_5678, 0, "R3 zero");
    run(32'hDEAD_BEEF, 1, 0, "R3 one");
    run(32'h8000_0001, 32'h8000_0000, 0, "R6 top bit");
    run(32'h0F0F_F0F0, 32'h3333_CCCC, 1, "R5 start ignored");
    for (int k = 0; k < 20; k++) run($urandom, $urandom, k[0], "R3 random");
    finished = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
  end

  initial begin
    wait (finished || fails > 0 && checks > 100000);
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) if (!finished && $time > 100000 * 8 - 10) begin
    #1; $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule